// File: doc/BRIEF.md
# Multi-Line Scanning Serial Transmitter

This block drives several asynchronous serial output lines from a single register window. Software marks the lines it wants to feed in a per-line enable register. A round-robin scanner looks for an enabled line whose one-character holding register is empty. When it finds one, it raises a ready flag and shows that line's number in the control register. Software then writes one character to a single shared data register, and the character is routed to the line the scanner named.

Each line has one holding register and one shift register, and no deeper queue. A line is offered again only after its holding register has passed the character on to the shifter. The frame format (5 to 8 data bits, optional even or odd parity, one or two stop bits) is common to all lines. Each line's bits are paced by its own baud tick input. An interrupt output follows the ready flag, gated by an enable bit. A self-timed clear sequence returns the whole block to its idle state.

Top module: `mux_tx_scanner`

## Requirements
- R1: After reset, the control and enable registers read 0, the format register reads 0x0003, every `txd` bit is 1 and `tx_irq` is 0.
- R2: Enable register (address 1) bit i belongs to line i and reads back as written. It is the only per-line busy indication.
- R3: Control register (address 0) bit 15 is the ready flag and bits [8 +: LINE_W] give the presented line. A line is presented only while it is enabled and its holding register is empty.
- R4: A write to the data register (address 2) while ready is 1 loads the character into the presented line only. A write while ready is 0 is ignored.
- R5: Ready reads 0 on the cycle after a data write. It is re-evaluated one cycle later.
- R6: `tx_irq` is 1 exactly when ready is 1 and the interrupt enable (control bit 2) is 1.
- R7: If the presented line's enable bit is cleared, ready drops on the next cycle, and the scanner moves to another line that wants data.
- R8: Nothing is presented while the scan enable (control bit 1) is 0.
- R9: Writing 1 to control bit 0 starts a clear that lasts CLR_CYCLES cycles. Bit 0 reads 1 during the clear and then 0. The clear zeroes the enable, scan and interrupt-enable bits and the line field, empties every line (all `txd` go to 1), and restores the format register to 0x0003.
- R10: The scanner searches round-robin, starting at the line after the last presented one. After a reset or clear, the search starts at line 1.
- R11: Frames go out as a start bit 0, then the data bits LSB first, then an optional parity bit, then stop bits of 1. The format register (address 3) sets these: bits[1:0] give the data bits minus 5, bit 2 enables parity, bit 3 selects odd parity (even otherwise), and bit 4 selects two stop bits. Each baud tick of a line ends its current bit.
- R12: While nothing is presented, the line field keeps its last value.
- R13: A line that holds a character while its shifter is busy is not presented. It is presented again once that character has moved into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 enable, 2 data, 3 format |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| baud_tick | input | NUM_LINES | Per-line bit-rate tick |
| txd | output | NUM_LINES | Serial outputs, idle high |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
The bound checker watches the cycle-level rules on every clock: ready falls after an accepted data write, a withdrawn presented line is dropped, nothing is presented with scanning off, at most one line is loaded per cycle, the line field holds while idle, and a clear leaves the outputs idle. Only the directed scenarios can show the rest. These are the round-robin order across all lines, the bit-exact frames for several formats and parities, the holding register delaying a second character, the exact length of the clear, and data writes with no line presented leaving every output untouched.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
   localparam int REG_W   = 16;
   localparam int CHAR_W  = 8;
   localparam int FRAME_W = 12;

   typedef enum logic [1:0] {
      ADR_CTRL    = 2'd0,
      ADR_LINE_EN = 2'd1,
      ADR_TXDATA  = 2'd2,
      ADR_FORMAT  = 2'd3
   } reg_addr_e;

   // control register bit positions
   localparam int CTL_CLR      = 0;
   localparam int CTL_SCAN     = 1;
   localparam int CTL_TXIE     = 2;
   localparam int CTL_LINE_LSB = 8;
   localparam int CTL_READY    = 15;

   typedef struct packed {
      logic       two_stop;
      logic       odd;
      logic       par_en;
      logic [1:0] len_code;   // data bits minus 5
   } fmt_t;

   localparam fmt_t FMT_RESET = '{two_stop: 1'b0, odd: 1'b0, par_en: 1'b0, len_code: 2'd3};
endpackage

// File: rtl/mtx_clr.sv
module mtx_clr #(
   parameter int CLR_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CLR_CYCLES + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start && (cnt_q == '0))
         cnt_q <= CW'(CLR_CYCLES);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);
endmodule

// File: rtl/mtx_line.sv
module mtx_line
   import mtx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load,
   input  logic [CHAR_W-1:0] ld_data,
   input  fmt_t              fmt,
   input  logic              tick,
   output logic              hold_full,
   output logic              txd
);
   logic [CHAR_W-1:0]  hold_q;
   logic               hold_full_q;
   logic               busy_q;
   logic [FRAME_W-1:0] frame_q;
   logic [3:0]         cnt_q;

   logic [FRAME_W-1:0] frame_new;
   logic [3:0]         len_new;
   logic [3:0]         db;
   logic [CHAR_W-1:0]  dmask;
   logic               par_bit;

   always_comb begin
      db        = 4'd5 + {2'b00, fmt.len_code};
      dmask     = 8'hFF >> (4'd8 - db);
      par_bit   = (^(hold_q & dmask)) ^ fmt.odd;
      frame_new = '1;
      frame_new[0] = 1'b0;
      for (int i = 0; i < CHAR_W; i++)
         if (4'(i) < db)
            frame_new[i + 1] = hold_q[i];
      if (fmt.par_en)
         frame_new[4'd1 + db] = par_bit;
      len_new = 4'd1 + db + {3'b000, fmt.par_en} + (fmt.two_stop ? 4'd2 : 4'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         busy_q      <= 1'b0;
         frame_q     <= '1;
         cnt_q       <= '0;
      end else if (clr) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
         busy_q      <= 1'b0;
         frame_q     <= '1;
         cnt_q       <= '0;
      end else begin
         if (load) begin
            hold_q      <= ld_data;
            hold_full_q <= 1'b1;
         end
         if (busy_q) begin
            if (tick) begin
               frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
               cnt_q   <= cnt_q - 1'b1;
               if (cnt_q == 4'd1)
                  busy_q <= 1'b0;
            end
         end else if (hold_full_q) begin
            frame_q     <= frame_new;
            cnt_q       <= len_new;
            busy_q      <= 1'b1;
            hold_full_q <= 1'b0;
         end
      end
   end

   assign hold_full = hold_full_q;
   assign txd       = busy_q ? frame_q[0] : 1'b1;
endmodule

// File: rtl/mtx_scan.sv
module mtx_scan #(
   parameter int NUM_LINES = 4,
   parameter int LINE_W    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 scan_en,
   input  logic [NUM_LINES-1:0] want,
   input  logic                 take,
   output logic                 ready,
   output logic [LINE_W-1:0]    line,
   output logic [NUM_LINES-1:0] load
);
   logic              ready_q;
   logic [LINE_W-1:0] line_q;
   logic              found;
   logic [LINE_W-1:0] nxt;

   always_comb begin
      found = 1'b0;
      nxt   = line_q;
      for (int off = 1; off <= NUM_LINES; off++) begin
         int s;
         logic [LINE_W-1:0] cand;
         s    = (int'(line_q) + off) % NUM_LINES;
         cand = LINE_W'(s);
         if (!found && want[cand]) begin
            found = 1'b1;
            nxt   = cand;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= 1'b0;
         line_q  <= '0;
      end else if (clr) begin
         ready_q <= 1'b0;
         line_q  <= '0;
      end else if (!scan_en) begin
         ready_q <= 1'b0;
      end else if (ready_q) begin
         if (take || !want[line_q])
            ready_q <= 1'b0;
      end else if (found) begin
         ready_q <= 1'b1;
         line_q  <= nxt;
      end
   end

   assign ready = ready_q;
   assign line  = line_q;
   assign load  = (take && ready_q) ? (NUM_LINES'(1) << line_q) : '0;
endmodule

// File: rtl/mux_tx_scanner.sv
module mux_tx_scanner
   import mtx_pkg::*;
#(
   parameter int NUM_LINES  = 4,
   parameter int CLR_CYCLES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           bus_addr,
   input  logic                 bus_wr,
   input  logic [REG_W-1:0]     bus_wdata,
   output logic [REG_W-1:0]     bus_rdata,
   input  logic [NUM_LINES-1:0] baud_tick,
   output logic [NUM_LINES-1:0] txd,
   output logic                 tx_irq
);
   localparam int LINE_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   if (NUM_LINES < 2 || NUM_LINES > 16) begin : g_bad_lines
      $error("NUM_LINES must be within 2..16");
   end
   if (CLR_CYCLES < 1) begin : g_bad_clr
      $error("CLR_CYCLES must be at least 1");
   end

   logic [NUM_LINES-1:0] line_en_q;
   logic                 scan_q;
   logic                 txie_q;
   fmt_t                 fmt_q;
   logic                 clr_busy;
   logic                 clr_start;
   logic                 take;
   logic                 ready_w;
   logic [LINE_W-1:0]    line_w;
   logic [NUM_LINES-1:0] load_w;
   logic [NUM_LINES-1:0] hold_full_w;
   logic [NUM_LINES-1:0] want;
   logic                 unused_wdata;

   assign unused_wdata = ^bus_wdata;

   assign clr_start = bus_wr && (bus_addr == ADR_CTRL) && bus_wdata[CTL_CLR] && !clr_busy;
   assign take      = bus_wr && (bus_addr == ADR_TXDATA) && !clr_busy;
   assign want      = line_en_q & ~hold_full_w;

   mtx_clr #(.CLR_CYCLES(CLR_CYCLES)) i_clr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (clr_start),
      .busy  (clr_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_en_q <= '0;
         scan_q    <= 1'b0;
         txie_q    <= 1'b0;
         fmt_q     <= FMT_RESET;
      end else if (clr_busy) begin
         line_en_q <= '0;
         scan_q    <= 1'b0;
         txie_q    <= 1'b0;
         fmt_q     <= FMT_RESET;
      end else if (bus_wr) begin
         case (bus_addr)
            ADR_CTRL: begin
               scan_q <= bus_wdata[CTL_SCAN];
               txie_q <= bus_wdata[CTL_TXIE];
            end
            ADR_LINE_EN: line_en_q <= bus_wdata[NUM_LINES-1:0];
            ADR_FORMAT:  fmt_q     <= fmt_t'(bus_wdata[$bits(fmt_t)-1:0]);
            default: ;
         endcase
      end
   end

   mtx_scan #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) i_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_busy),
      .scan_en (scan_q),
      .want    (want),
      .take    (take),
      .ready   (ready_w),
      .line    (line_w),
      .load    (load_w)
   );

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      mtx_line i_line (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (clr_busy),
         .load      (load_w[g]),
         .ld_data   (bus_wdata[CHAR_W-1:0]),
         .fmt       (fmt_q),
         .tick      (baud_tick[g]),
         .hold_full (hold_full_w[g]),
         .txd       (txd[g])
      );
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADR_CTRL: begin
            bus_rdata[CTL_CLR]                 = clr_busy;
            bus_rdata[CTL_SCAN]                = scan_q;
            bus_rdata[CTL_TXIE]                = txie_q;
            bus_rdata[CTL_LINE_LSB +: LINE_W]  = line_w;
            bus_rdata[CTL_READY]               = ready_w;
         end
         ADR_LINE_EN: bus_rdata[NUM_LINES-1:0]   = line_en_q;
         ADR_FORMAT:  bus_rdata[$bits(fmt_t)-1:0] = fmt_q;
         default: ;
      endcase
   end

   assign tx_irq = ready_w & txie_q;
endmodule

// File: rtl/mux_tx_chk.sv
module mux_tx_chk
   import mtx_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int LINE_W    = 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic [1:0]           bus_addr,
   input logic                 ready,
   input logic [LINE_W-1:0]    line,
   input logic                 scan_en,
   input logic                 clr_busy,
   input logic [NUM_LINES-1:0] line_en,
   input logic [NUM_LINES-1:0] load,
   input logic [NUM_LINES-1:0] txd
);
   // R5: an accepted data write takes the ready flag down
   a_r5_drop_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADR_TXDATA && ready && !clr_busy) |=> !ready);

   // R7: a withdrawn presented line is abandoned
   a_r7_abandon: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !line_en[line]) |=> !ready);

   // R8: no presentation with scanning off
   a_r8_no_scan: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |=> !ready);

   // R12: the line field holds while nothing is presented
   a_r12_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !clr_busy) |=> (ready || $stable(line)));

   // R4: at most one line takes a character per cycle
   a_r4_one_load: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load));

   // R9: a running clear leaves every output idle and nothing presented
   a_r9_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      clr_busy |=> (!ready && (&txd)));
endmodule

bind mux_tx_scanner mux_tx_chk #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .ready    (ready_w),
   .line     (line_w),
   .scan_en  (scan_q),
   .clr_busy (clr_busy),
   .line_en  (line_en_q),
   .load     (load_w),
   .txd      (txd)
);

// File: tb/test_mux_tx_scanner.sv
`timescale 1ns/1ps
module test_mux_tx_scanner;
   localparam int N   = 4;
   localparam int CLR = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [1:0]    bus_addr;
   logic          bus_wr;
   logic [15:0]   bus_wdata;
   logic [15:0]   bus_rdata;
   logic [N-1:0]  baud_tick;
   logic [N-1:0]  txd;
   logic          tx_irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;   // 200 MHz

   mux_tx_scanner #(.NUM_LINES(N), .CLR_CYCLES(CLR)) i_mux_tx_scanner (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .baud_tick (baud_tick),
      .txd       (txd),
      .tx_irq    (tx_irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      bus_addr = a;
      #0.5;
      v = bus_rdata;
   endtask

   task automatic tick(input int ln);
      @(negedge clk);
      baud_tick[ln] = 1'b1;
      @(negedge clk);
      baud_tick[ln] = 1'b0;
   endtask

   task automatic build_frame(input logic [7:0] d, input logic [4:0] f,
                              output logic [11:0] bits, output int len);
      int db;
      logic p;
      db = 5 + int'(f[1:0]);
      bits = '1;
      bits[0] = 1'b0;
      p = f[3];
      for (int i = 0; i < db; i++) begin
         bits[1 + i] = d[i];
         p = p ^ d[i];
      end
      if (f[2]) bits[1 + db] = p;
      len = 1 + db + int'(f[2]) + (f[4] ? 2 : 1);
   endtask

   // start bit is already on the line when this is called
   task automatic frame_check(input int ln, input logic [7:0] d, input logic [4:0] f);
      logic [11:0] bits;
      int len;
      build_frame(d, f, bits, len);
      for (int k = 1; k < len; k++) begin
         tick(ln);
         check($sformatf("R11 line %0d bit %0d", ln, k), 32'(txd[ln]), 32'(bits[k]));
      end
      tick(ln);
      check("R11 idle after frame", 32'(txd[ln]), 32'd1);
   endtask

   task automatic wait_ready(input int ln);
      logic [15:0] v;
      for (int i = 0; i < 40; i++) begin
         rd(2'd0, v);
         if (v[15]) break;
         cyc(1);
      end
      check("R3 ready present", 32'(v[15]), 32'd1);
      check("R10 presented line", 32'(v[9:8]), 32'(ln));
   endtask

   task automatic send(input int ln, input logic [7:0] d, input logic [4:0] f);
      wait_ready(ln);
      wr(2'd2, {8'h00, d});
      cyc(1);
      check("R11 start bit", 32'(txd[ln]), 32'd0);
      frame_check(ln, d, f);
   endtask

   task automatic t_reset;
      logic [15:0] v;
      rd(2'd0, v); check("R1 ctrl", 32'(v), 32'h0);
      rd(2'd1, v); check("R1 enable", 32'(v), 32'h0);
      rd(2'd3, v); check("R1 format", 32'(v), 32'h3);
      check("R1 txd idle", 32'(txd), 32'hF);
      check("R1 irq", 32'(tx_irq), 32'd0);
   endtask

   task automatic t_no_scan;
      logic [15:0] v;
      wr(2'd1, 16'h000A);
      rd(2'd1, v); check("R2 enable readback", 32'(v), 32'hA);
      wr(2'd2, 16'h0000);   // nothing presented: must be ignored
      cyc(3);
      check("R4 ignored write leaves txd", 32'(txd), 32'hF);
      rd(2'd0, v); check("R8 no ready without scan", 32'(v[15]), 32'd0);
   endtask

   task automatic t_present_irq;
      logic [15:0] v;
      wr(2'd0, 16'h0006);
      cyc(1);
      rd(2'd0, v); check("R10 first line after reset", 32'(v), 32'h8106);
      check("R6 irq on", 32'(tx_irq), 32'd1);
      wr(2'd0, 16'h0002);
      rd(2'd0, v); check("R6 ready kept", 32'(v), 32'h8102);
      check("R6 irq masked", 32'(tx_irq), 32'd0);
      wr(2'd0, 16'h0006);
      check("R6 irq back", 32'(tx_irq), 32'd1);
   endtask

   task automatic t_write_advance;
      logic [15:0] v;
      wr(2'd2, 16'h0055);
      rd(2'd0, v); check("R5 ready drops after write", 32'(v), 32'h0106);
      cyc(1);
      rd(2'd0, v); check("R10 next line 3", 32'(v), 32'h8306);
      check("R4 start on line 1", 32'(txd), 32'hD);
      frame_check(1, 8'h55, 5'h03);
   endtask

   task automatic t_abandon;
      logic [15:0] v;
      wr(2'd1, 16'h0002);
      rd(2'd0, v); check("R7 still shown", 32'(v), 32'h8306);
      cyc(1);
      rd(2'd0, v); check("R7 abandoned, R12 field kept", 32'(v), 32'h0306);
      cyc(1);
      rd(2'd0, v); check("R7 moved to line 1", 32'(v), 32'h8106);
   endtask

   task automatic t_holding;
      logic [15:0] v;
      wr(2'd2, 16'h00A3);
      cyc(1);
      rd(2'd0, v); check("R13 not shown while holding full", 32'(v), 32'h0106);
      cyc(1);
      rd(2'd0, v); check("R13 shown once moved", 32'(v), 32'h8106);
      wr(2'd2, 16'h003C);
      cyc(4);
      rd(2'd0, v); check("R13 held char blocks, R12 field kept", 32'(v), 32'h0106);
      check("R13 first frame still at start", 32'(txd[1]), 32'd0);
      frame_check(1, 8'hA3, 5'h03);
      cyc(1);
      check("R13 held char starts", 32'(txd[1]), 32'd0);
      frame_check(1, 8'h3C, 5'h03);
   endtask

   task automatic t_formats;
      logic [15:0] v;
      wr(2'd3, 16'h0014);
      rd(2'd3, v); check("R11 format readback", 32'(v), 32'h14);
      send(1, 8'h1D, 5'h14);
      wr(2'd3, 16'h000E);
      send(1, 8'h41, 5'h0E);
   endtask

   task automatic t_clear;
      logic [15:0] v;
      wait_ready(1);
      wr(2'd2, 16'h0000);
      cyc(1);
      check("R9 line busy before clear", 32'(txd[1]), 32'd0);
      wr(2'd0, 16'h0001);
      rd(2'd0, v); check("R9 clear bit reads 1", 32'(v[0]), 32'd1);
      cyc(CLR - 1);
      rd(2'd0, v); check("R9 clear bit 1 in last cycle", 32'(v[0]), 32'd1);
      cyc(1);
      rd(2'd0, v); check("R9 ctrl after clear", 32'(v), 32'h0);
      rd(2'd1, v); check("R9 enable after clear", 32'(v), 32'h0);
      rd(2'd3, v); check("R9 format after clear", 32'(v), 32'h3);
      check("R9 txd idle after clear", 32'(txd), 32'hF);
   endtask

   task automatic t_round_robin;
      logic [15:0] v;
      int order[4] = '{2, 3, 0, 1};
      wr(2'd1, 16'h000F);
      wr(2'd0, 16'h0006);
      cyc(1);
      rd(2'd0, v); check("R10 start at line 1", 32'(v), 32'h8106);
      foreach (order[i]) begin
         wr(2'd2, 16'(i));
         cyc(1);
         rd(2'd0, v);
         check($sformatf("R10 rotation step %0d", i), 32'(v), 32'h8006 | (32'(order[i]) << 8));
      end
   endtask

   initial begin
      rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; baud_tick = '0;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_no_scan();
      t_present_irq();
      t_write_advance();
      t_abandon();
      t_holding();
      t_formats();
      t_clear();
      t_round_robin();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule